// File: doc/BRIEF.md
# Four-State Snooping Coherence Tag Controller

This block keeps the coherence state of every line in one private cache that sits on a shared, time-multiplexed bus in a small symmetric multiprocessor. It holds no data. It keeps a directly indexed array of two-bit line states and moves them under two kinds of traffic. One is the local processor's read and write requests. The other is bus transactions from other agents, which arrive on a snoop port as either a read or a read-for-ownership/invalidate.

A local request is decoded against the line's current state within the cycle. If the bus must be used, the block raises a bus request (read, read-exclusive or invalidate) in that same cycle. On a read miss it also samples the shared-line response of the other caches in that cycle, and this response decides whether the line is installed as Exclusive or as Shared. A snooped transaction answers at once with a shared response and, if this cache holds the line dirty, with a write-back request. If a snoop and a local request hit the same index in one cycle, the snoop is applied first and the local request then acts on the resulting state. All state changes become visible after the next rising clock edge.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid on `state_out`. The state encodings are Invalid=00, Shared=01, Exclusive=10 and Modified=11, and line i occupies bits [2i+1:2i].
- R2: A local read of an Invalid line raises `bus_req_valid` with `bus_req_op`=01 (read) in the same cycle. The line becomes Exclusive if `shared_in` is low in that cycle and Shared if it is high.
- R3: A local read of a Shared, Exclusive or Modified line raises no bus request and leaves the state unchanged.
- R4: A local write to an Exclusive or Modified line raises no bus request, and the line ends Modified.
- R5: A local write to a Shared line raises a bus request with `bus_req_op`=11 (invalidate), and the line ends Modified.
- R6: A local write to an Invalid line raises a bus request with `bus_req_op`=10 (read-exclusive), and the line ends Modified.
- R7: A snooped read (`snp_kind`=0) moves an Exclusive line to Shared, leaves a Shared line Shared, and leaves an Invalid line Invalid, all without a write-back.
- R8: A snooped read of a Modified line raises `wb_req` in the same cycle, and the line ends Shared.
- R9: A snooped read-for-ownership/invalidate (`snp_kind`=1) moves any line to Invalid. `wb_req` is raised in that cycle only if the line was Modified.
- R10: `snp_shared_out` is high during a snoop cycle exactly when the addressed line is Shared, Exclusive or Modified, whatever the snoop kind.
- R11: When a snoop and a local request address the same index in one cycle, the snoop's transition is applied first. The local request's bus request and final state are then derived from the post-snoop state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Local processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_idx | input | IDX_W | Line index of the local request |
| shared_in | input | 1 | Shared-line response from other caches, sampled on a local read miss |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_kind | input | 1 | 0 = read, 1 = read-for-ownership/invalidate |
| snp_idx | input | IDX_W | Line index of the snooped transaction |
| bus_req_valid | output | 1 | Bus transaction requested for the local request |
| bus_req_op | output | 2 | 01 read, 10 read-exclusive, 11 invalidate, 00 none |
| wb_req | output | 1 | Write back the snooped dirty line |
| snp_shared_out | output | 1 | This cache holds the snooped line |
| state_out | output | 2*2^IDX_W | Registered state of every line |

## Verification
The hardest situation to reach from the ports is a snoop and a local request on the same index in one cycle. In that cycle the bus request must already reflect the snoop's transition, for example a write to a Modified line that is being invalidated by the snoop, which must turn into a read-exclusive. The bench drives every line through every state using only port-level sequences: a snooped invalidate forces Invalid, then a read with or without `shared_in`, or a write. It then applies each operation to each state. After that it forces each state on one line and fires every combination of local operation and snoop kind at that line in the same cycle. The expected results come from a shadow state array held in the bench.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_e;

    typedef enum logic [1:0] {
        BUS_NONE = 2'b00,
        BUS_RD   = 2'b01,
        BUS_RDX  = 2'b10,
        BUS_INV  = 2'b11
    } bus_op_e;

endpackage

// File: rtl/mesi_snoop_xfer.sv
// Snoop-side transition for one line: next state, dirty write-back, presence.
module mesi_snoop_xfer
    import mesi_pkg::*;
(
    input  mesi_e cur,
    input  logic  own,
    output mesi_e nxt,
    output logic  wb,
    output logic  hit
);
    always_comb begin
        hit = (cur != ST_I);
        wb  = (cur == ST_M);
        nxt = cur;
        if (hit) begin
            nxt = own ? ST_I : ST_S;
        end
    end
endmodule

// File: rtl/mesi_local_xfer.sv
// Processor-side transition for one line: next state and bus operation.
module mesi_local_xfer
    import mesi_pkg::*;
(
    input  mesi_e   cur,
    input  logic    write,
    input  logic    shared_in,
    output mesi_e   nxt,
    output bus_op_e op
);
    always_comb begin
        nxt = cur;
        op  = BUS_NONE;
        if (write) begin
            nxt = ST_M;
            case (cur)
                ST_I:    op = BUS_RDX;
                ST_S:    op = BUS_INV;
                default: op = BUS_NONE;
            endcase
        end else if (cur == ST_I) begin
            op  = BUS_RD;
            nxt = shared_in ? ST_S : ST_E;
        end
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cpu_req_valid,
    input  logic                        cpu_req_write,
    input  logic [IDX_W-1:0]            cpu_req_idx,
    input  logic                        shared_in,
    input  logic                        snp_valid,
    input  logic                        snp_kind,
    input  logic [IDX_W-1:0]            snp_idx,
    output logic                        bus_req_valid,
    output logic [1:0]                  bus_req_op,
    output logic                        wb_req,
    output logic                        snp_shared_out,
    output logic [2*(1<<IDX_W)-1:0]     state_out
);
    localparam int NLINES = 1 << IDX_W;

    typedef struct packed {
        mesi_e [NLINES-1:0] line;
    } tags_t;

    tags_t   st_d, st_q;
    mesi_e   snp_cur, snp_nxt, loc_cur, loc_nxt;
    logic    snp_wb, snp_hit, collide;
    bus_op_e loc_op;

    assign snp_cur = st_q.line[snp_idx];
    assign collide = snp_valid && (snp_idx == cpu_req_idx);
    // Snoop wins the index: the local request sees the post-snoop state.
    assign loc_cur = collide ? snp_nxt : st_q.line[cpu_req_idx];

    mesi_snoop_xfer u_snoop (
        .cur (snp_cur),
        .own (snp_kind),
        .nxt (snp_nxt),
        .wb  (snp_wb),
        .hit (snp_hit)
    );

    mesi_local_xfer u_local (
        .cur       (loc_cur),
        .write     (cpu_req_write),
        .shared_in (shared_in),
        .nxt       (loc_nxt),
        .op        (loc_op)
    );

    always_comb begin
        st_d = st_q;
        if (snp_valid) begin
            st_d.line[snp_idx] = snp_nxt;
        end
        if (cpu_req_valid) begin
            st_d.line[cpu_req_idx] = loc_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_req_valid  = cpu_req_valid && (loc_op != BUS_NONE);
    assign bus_req_op     = cpu_req_valid ? loc_op : BUS_NONE;
    assign wb_req         = snp_valid && snp_wb;
    assign snp_shared_out = snp_valid && snp_hit;
    assign state_out      = st_q;

endmodule

// File: rtl/mesi_line_chk.sv
module mesi_line_chk #(
    parameter int IDX_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cpu_req_valid,
    input logic                    cpu_req_write,
    input logic [IDX_W-1:0]        cpu_req_idx,
    input logic                    snp_valid,
    input logic                    snp_kind,
    input logic [IDX_W-1:0]        snp_idx,
    input logic                    bus_req_valid,
    input logic [1:0]              bus_req_op,
    input logic                    wb_req,
    input logic                    snp_shared_out,
    input logic [2*(1<<IDX_W)-1:0] state_out
);
    logic [1:0] snp_line, cpu_line;
    logic       same;
    assign snp_line = state_out[{snp_idx, 1'b0} +: 2];
    assign cpu_line = state_out[{cpu_req_idx, 1'b0} +: 2];
    assign same     = cpu_req_valid && snp_valid && (cpu_req_idx == snp_idx);

    p_reset_inv_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> state_out == '0);

    p_miss_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && !cpu_req_write && cpu_line == 2'b00 && !snp_valid
        |-> bus_req_valid && bus_req_op == 2'b01);

    p_wr_ends_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_write
        |=> state_out[{$past(cpu_req_idx), 1'b0} +: 2] == 2'b11);

    p_mod_wr_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_write && cpu_line == 2'b11 && !snp_valid
        |-> !bus_req_valid);

    p_snp_mod_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_line == 2'b11 |-> wb_req);

    p_snp_rd_mod_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && !snp_kind && snp_line == 2'b11 && !same
        |=> state_out[{$past(snp_idx), 1'b0} +: 2] == 2'b01);

    p_snp_own_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_kind && !same
        |=> state_out[{$past(snp_idx), 1'b0} +: 2] == 2'b00);

    p_snp_present_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_line != 2'b00 |-> snp_shared_out);

endmodule

bind mesi_line_ctrl mesi_line_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;
    localparam int IDX_W  = 3;
    localparam int NL     = 1 << IDX_W;
    localparam logic [1:0] I = 2'b00, S = 2'b01, E = 2'b10, M = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req_valid = 0, cpu_req_write = 0, shared_in = 0;
    logic snp_valid = 0, snp_kind = 0;
    logic [IDX_W-1:0] cpu_req_idx = '0, snp_idx = '0;
    logic bus_req_valid, wb_req, snp_shared_out;
    logic [1:0] bus_req_op;
    logic [2*NL-1:0] state_out;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [1:0] sh [NL];

    always #5 clk = ~clk;

    mesi_line_ctrl #(.IDX_W(IDX_W)) dut (.*);

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [2*NL-1:0] pack_sh();
        logic [2*NL-1:0] v;
        for (int i = 0; i < NL; i++) v[2*i +: 2] = sh[i];
        return v;
    endfunction

    task automatic do_op(input int idx, input bit cv, input bit cw, input bit shin,
                         input bit sv, input bit sk, input int sidx);
        logic [1:0] post [NL];
        logic [1:0] pre_l, pre_s, cur;
        logic       e_bv, e_wb, e_shr;
        logic [1:0] e_op;
        string      tag;
        for (int i = 0; i < NL; i++) post[i] = sh[i];
        pre_l = sh[idx];
        pre_s = sh[sidx];
        e_wb  = sv && pre_s == M;
        e_shr = sv && pre_s != I;
        if (sv && pre_s != I) post[sidx] = sk ? I : S;
        cur  = post[idx];
        e_op = 2'b00;
        if (cv) begin
            if (cw) begin
                if (cur == I) e_op = 2'b10;
                else if (cur == S) e_op = 2'b11;
                post[idx] = M;
            end else if (cur == I) begin
                e_op = 2'b01;
                post[idx] = shin ? S : E;
            end
        end
        e_bv = (e_op != 2'b00);
        if (cv && sv && idx == sidx) tag = "R11";
        else if (sv) tag = sk ? "R9" : (pre_s == M ? "R8" : "R7");
        else if (cw) tag = (pre_l == I) ? "R6" : (pre_l == S) ? "R5" : "R4";
        else tag = (pre_l == I) ? "R2" : "R3";

        @(negedge clk);
        cpu_req_valid = cv; cpu_req_write = cw; cpu_req_idx = idx[IDX_W-1:0];
        shared_in = shin; snp_valid = sv; snp_kind = sk; snp_idx = sidx[IDX_W-1:0];
        #1;
        chk(tag, "bus_req_valid", 32'(bus_req_valid), 32'(e_bv));
        chk(tag, "bus_req_op", 32'(bus_req_op), 32'(e_op));
        chk(tag, "wb_req", 32'(wb_req), 32'(e_wb));
        if (sv) chk("R10", "snp_shared_out", 32'(snp_shared_out), 32'(e_shr));
        @(posedge clk);
        #1;
        cpu_req_valid = 0; snp_valid = 0; shared_in = 0;
        for (int i = 0; i < NL; i++) sh[i] = post[i];
        chk(tag, "state_out", 32'(state_out), 32'(pack_sh()));
    endtask

    // Force one line into a state using only port-level traffic.
    task automatic set_state(input int idx, input logic [1:0] s);
        do_op(0, 0, 0, 0, 1, 1, idx);
        case (s)
            S: do_op(idx, 1, 0, 1, 0, 0, 0);
            E: do_op(idx, 1, 0, 0, 0, 0, 0);
            M: do_op(idx, 1, 1, 0, 0, 0, 0);
            default: ;
        endcase
    endtask

    initial begin
        for (int i = 0; i < NL; i++) sh[i] = I;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "state_out after reset", 32'(state_out), 32'h0);
        chk("R1", "bus idle after reset", 32'(bus_req_valid), 32'h0);

        // Sweep: every line, every starting state, every single operation.
        for (int idx = 0; idx < NL; idx++) begin
            for (int s = 0; s < 4; s++) begin
                for (int op = 0; op < 5; op++) begin
                    set_state(idx, 2'(s));
                    case (op)
                        0: do_op(idx, 1, 0, 0, 0, 0, 0);
                        1: do_op(idx, 1, 0, 1, 0, 0, 0);
                        2: do_op(idx, 1, 1, 0, 0, 0, 0);
                        3: do_op(0, 0, 0, 0, 1, 0, idx);
                        default: do_op(0, 0, 0, 0, 1, 1, idx);
                    endcase
                end
            end
        end

        // R11: local request and snoop on the same index in one cycle.
        for (int s = 0; s < 4; s++) begin
            for (int op = 0; op < 3; op++) begin
                for (int k = 0; k < 2; k++) begin
                    set_state(5, 2'(s));
                    do_op(5, 1, op == 2, op == 1, 1, k[0], 5);
                end
            end
        end

        // Snoop and local request on different lines in one cycle.
        set_state(2, M);
        set_state(3, S);
        do_op(3, 1, 1, 0, 1, 0, 2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule